// File: doc/BRIEF.md
# I2C Clock Phase Timing Generator

This block produces the serial clock of a single-master I2C port from a fast reference clock. It also places the data line edges that make up START, repeated START and STOP conditions. A byte engine sits above it and issues one command at a time. Each command is a data bit, a START, a STOP or a timed wait. The generator drives both lines as open-drain pull-down enables and reports two things: the end of every timed phase, and the completion of each command.

Phase lengths come from a programmable low count and high count. Each count is multiplied by a prescale that a 2-bit speed mode selects. Each mode also sets a floor under both counts, and smaller programmed values are raised to that floor. With a 156 MHz reference, the top speed mode and the counts 94/63 give an SCL close to 1 MHz. A phase with SCL released does not begin its count until the line is seen high, so a slave can stretch the clock. The settings are copied into shadow registers only while the generator is idle, so a command always runs with one consistent timing.

Top module: `scl_phase_gen`

## Requirements
- R1: After reset, both lines are released (`scl_drive_low` = 0, `sda_drive_low` = 0), `cmd_ready` is 1 and `cmd_done` is 0.
- R2: `cfg_mode` selects the prescale and the count floors: 00 gives prescale 8 with floors 118/79, 01 gives prescale 4 with floors 59/39, and 10 gives prescale 1 with floors 94/63. Code 11 behaves exactly like 00.
- R3: A bit command (`cmd_op` = 00) first drives SCL low for low_eff × scale cycles, then releases SCL for high_eff × scale cycles. SDA is driven low through both phases when `cmd_bit` = 0 and released through both when `cmd_bit` = 1.
- R4: The effective count low_eff (and likewise high_eff) is the larger of the programmed count and the floor of the mode.
- R5: In every phase that releases SCL after driving it low, the count stands still for each cycle in which `scl_line` is low. The released time is therefore the stretch cycles plus high_eff × scale.
- R6: A START (`cmd_op` = 01) on a free bus drives SDA low with SCL released for high_eff × scale cycles. SCL is then driven low, and the bus is owned.
- R7: A START on an owned bus is a repeated START with three phases. SCL is low and SDA released for low_eff × scale cycles. Both lines are then released for high_eff × scale cycles. Last, SDA is driven low with SCL released for high_eff × scale cycles.
- R8: A STOP (`cmd_op` = 10) on an owned bus has three phases. SCL and SDA are low for low_eff × scale cycles. SDA stays low with SCL released for high_eff × scale cycles. Both lines are then released for a bus-free time of low_eff × scale cycles, and the bus ends free. A STOP on a free bus completes in the cycle after acceptance and changes neither line.
- R9: A wait command (`cmd_op` = 11) holds both lines at their current levels for low_eff × scale cycles.
- R10: A command is accepted only while `cmd_ready` is 1. A request made while a command runs has no effect. `cmd_done` is a one-cycle pulse in the first cycle with `cmd_ready` high again.
- R11: Timing settings are captured only in idle cycles with no request pending. A change made while a command runs does not affect that command, and it applies to the next command after an idle cycle.
- R12: `phase_end` pulses once in the final cycle of each timed phase: twice for a bit, once for a START on a free bus, three times for a repeated START or an owned STOP, once for a wait, and never for a STOP on a free bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | Speed mode selecting prescale and count floors |
| cfg_low_cnt | input | 8 | Programmed SCL low count |
| cfg_high_cnt | input | 8 | Programmed SCL high count |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | Command: 00 bit, 01 START, 10 STOP, 11 wait |
| cmd_bit | input | 1 | Data value for a bit command |
| cmd_ready | output | 1 | Idle and able to accept a command |
| cmd_done | output | 1 | Command completed (one-cycle pulse) |
| phase_end | output | 1 | Final cycle of a timed phase |
| scl_line | input | 1 | Sampled level of the SCL wire |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |

## Verification
The bench runs each speed mode, including the reserved code. It uses counts both above and below the floors, so a design that drops the floor, scales by the wrong factor or takes code 11 as its own mode produces phase lengths visibly off. It stretches SCL at the start of a bit high phase and of a STOP setup phase. A generator that counts while the line is held low would end the phase early by exactly the stretch length. It also changes the settings and issues a stray STOP in the middle of a running bit. A design without frozen shadows would switch the phase lengths in mid-bit, and one that accepts requests while busy would release the bus.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

  localparam int CNT_W = 8;
  localparam int PRE_W = 3;

  typedef enum logic [1:0] {
    OP_BIT   = 2'b00,
    OP_START = 2'b01,
    OP_STOP  = 2'b10,
    OP_WAIT  = 2'b11
  } op_e;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_BIT_LO,
    PH_BIT_HI,
    PH_RS_LO,
    PH_RS_SU,
    PH_STA_HD,
    PH_STO_LO,
    PH_STO_SU,
    PH_STO_BUF,
    PH_WAIT
  } phase_e;

  typedef struct packed {
    logic [CNT_W-1:0] lo;
    logic [CNT_W-1:0] hi;
    logic [PRE_W-1:0] pre_m1;
  } timing_t;

  // prescale minus one per speed mode; reserved falls back to the slow mode
  function automatic logic [PRE_W-1:0] pre_m1_of(input logic [1:0] mode);
    case (mode)
      2'b01:   return PRE_W'(3);
      2'b10:   return PRE_W'(0);
      default: return PRE_W'(7);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] floor_lo(input logic [1:0] mode);
    case (mode)
      2'b01:   return CNT_W'(59);
      2'b10:   return CNT_W'(94);
      default: return CNT_W'(118);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] floor_hi(input logic [1:0] mode);
    case (mode)
      2'b01:   return CNT_W'(39);
      2'b10:   return CNT_W'(63);
      default: return CNT_W'(79);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] raise_to(input logic [CNT_W-1:0] v,
                                                input logic [CNT_W-1:0] fl);
    return (v < fl) ? fl : v;
  endfunction

  // phases whose length comes from the high count
  function automatic logic uses_high(input phase_e p);
    return (p == PH_BIT_HI) || (p == PH_RS_SU) || (p == PH_STA_HD) || (p == PH_STO_SU);
  endfunction

  // phases that release SCL after it was low and so must see it rise
  function automatic logic may_stall(input phase_e p);
    return (p == PH_BIT_HI) || (p == PH_RS_SU) || (p == PH_STO_SU);
  endfunction

endpackage

// File: rtl/sclgen_cfg_shadow.sv
module sclgen_cfg_shadow
  import sclgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] low_cnt,
  input  logic [CNT_W-1:0] high_cnt,
  output timing_t          tmg
);
  localparam int NFLD = 2;

  logic [CNT_W-1:0] raw_v [NFLD];
  logic [CNT_W-1:0] flr_v [NFLD];
  logic [PRE_W-1:0] pre_q;

  assign raw_v[0] = low_cnt;
  assign raw_v[1] = high_cnt;
  assign flr_v[0] = floor_lo(mode);
  assign flr_v[1] = floor_hi(mode);

  for (genvar i = 0; i < NFLD; i++) begin : g_fld
    localparam logic [CNT_W-1:0] RST_V = (i == 0) ? floor_lo(2'b00) : floor_hi(2'b00);
    logic [CNT_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= RST_V;
      else if (capture) q <= raise_to(raw_v[i], flr_v[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre_q <= pre_m1_of(2'b00);
    else if (capture) pre_q <= pre_m1_of(mode);
  end

  assign tmg.lo     = g_fld[0].q;
  assign tmg.hi     = g_fld[1].q;
  assign tmg.pre_m1 = pre_q;

  // R4
  eff_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmg.lo >= CNT_W'(59)) && (tmg.hi >= CNT_W'(39)));

endmodule

// File: rtl/sclgen_phase_ctr.sv
module sclgen_phase_ctr
  import sclgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic [PRE_W-1:0] pre_m1,
  input  logic             active,
  input  logic             stall,
  output logic             last
);
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      pre_q <= pre_m1;
      cnt_q <= load_cnt;
    end else if (active && !stall) begin
      if (pre_q != '0) begin
        pre_q <= pre_q - PRE_W'(1);
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - CNT_W'(1);
        pre_q <= pre_m1;
      end
    end
  end

  assign last = active && !stall && (pre_q == '0) && (cnt_q == '0);

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && stall) |=> ($stable(cnt_q) && $stable(pre_q)));

endmodule

// File: rtl/sclgen_seq.sv
module sclgen_seq
  import sclgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic             cmd_bit,
  input  logic             scl_line,
  input  timing_t          tmg,
  input  logic             last,
  output logic             cmd_ready,
  output logic             cmd_done,
  output logic             load,
  output logic [CNT_W-1:0] load_cnt,
  output logic             active,
  output logic             stall,
  output logic             scl_drive_low,
  output logic             sda_drive_low
);
  phase_e ph_q, ph_nx;
  logic   owned_q, sda_q, bit_q, done_q;
  logic   accept;

  assign cmd_ready = (ph_q == PH_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign active    = !cmd_ready;
  assign stall     = may_stall(ph_q) && !scl_line;

  always_comb begin
    ph_nx = ph_q;
    if (accept) begin
      case (op_e'(cmd_op))
        OP_BIT:   ph_nx = PH_BIT_LO;
        OP_START: ph_nx = owned_q ? PH_RS_LO : PH_STA_HD;
        OP_STOP:  ph_nx = owned_q ? PH_STO_LO : PH_IDLE;
        default:  ph_nx = PH_WAIT;
      endcase
    end else if (last) begin
      case (ph_q)
        PH_BIT_LO: ph_nx = PH_BIT_HI;
        PH_RS_LO:  ph_nx = PH_RS_SU;
        PH_RS_SU:  ph_nx = PH_STA_HD;
        PH_STO_LO: ph_nx = PH_STO_SU;
        PH_STO_SU: ph_nx = PH_STO_BUF;
        default:   ph_nx = PH_IDLE;
      endcase
    end
  end

  assign load     = (accept || last) && (ph_nx != PH_IDLE);
  assign load_cnt = (uses_high(ph_nx) ? tmg.hi : tmg.lo) - CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      owned_q <= 1'b0;
      sda_q   <= 1'b0;
      bit_q   <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      ph_q   <= ph_nx;
      done_q <= (accept || last) && (ph_nx == PH_IDLE);
      if (accept) bit_q <= cmd_bit;
      if (last) begin
        case (ph_q)
          PH_BIT_HI:  begin owned_q <= 1'b1; sda_q <= ~bit_q; end
          PH_STA_HD:  begin owned_q <= 1'b1; sda_q <= 1'b1;   end
          PH_STO_BUF: begin owned_q <= 1'b0; sda_q <= 1'b0;   end
          default:    ;
        endcase
      end
    end
  end

  assign cmd_done = done_q;

  always_comb begin
    case (ph_q)
      PH_BIT_LO:  begin scl_drive_low = 1'b1; sda_drive_low = ~bit_q; end
      PH_BIT_HI:  begin scl_drive_low = 1'b0; sda_drive_low = ~bit_q; end
      PH_RS_LO:   begin scl_drive_low = 1'b1; sda_drive_low = 1'b0;   end
      PH_RS_SU:   begin scl_drive_low = 1'b0; sda_drive_low = 1'b0;   end
      PH_STA_HD:  begin scl_drive_low = 1'b0; sda_drive_low = 1'b1;   end
      PH_STO_LO:  begin scl_drive_low = 1'b1; sda_drive_low = 1'b1;   end
      PH_STO_SU:  begin scl_drive_low = 1'b0; sda_drive_low = 1'b1;   end
      PH_STO_BUF: begin scl_drive_low = 1'b0; sda_drive_low = 1'b0;   end
      default:    begin scl_drive_low = owned_q; sda_drive_low = sda_q; end
    endcase
  end

  // R10
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> cmd_ready);

  // R3
  sda_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph_q == PH_BIT_HI) && $past(ph_q == PH_BIT_HI)) |-> $stable(sda_drive_low));

  // R8
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && $past(ph_q == PH_STO_BUF)) |-> (!scl_drive_low && !sda_drive_low));

endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
  import sclgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_mode,
  input  logic [CNT_W-1:0] cfg_low_cnt,
  input  logic [CNT_W-1:0] cfg_high_cnt,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic             cmd_bit,
  output logic             cmd_ready,
  output logic             cmd_done,
  output logic             phase_end,
  input  logic             scl_line,
  output logic             scl_drive_low,
  output logic             sda_drive_low
);
  timing_t          tmg;
  logic             capture;
  logic             ctr_load, ctr_active, ctr_stall, ctr_last;
  logic [CNT_W-1:0] ctr_load_cnt;

  assign capture = cmd_ready && !cmd_valid;

  sclgen_cfg_shadow u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (capture),
    .mode     (cfg_mode),
    .low_cnt  (cfg_low_cnt),
    .high_cnt (cfg_high_cnt),
    .tmg      (tmg)
  );

  sclgen_phase_ctr u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ctr_load),
    .load_cnt (ctr_load_cnt),
    .pre_m1   (tmg.pre_m1),
    .active   (ctr_active),
    .stall    (ctr_stall),
    .last     (ctr_last)
  );

  sclgen_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_op        (cmd_op),
    .cmd_bit       (cmd_bit),
    .scl_line      (scl_line),
    .tmg           (tmg),
    .last          (ctr_last),
    .cmd_ready     (cmd_ready),
    .cmd_done      (cmd_done),
    .load          (ctr_load),
    .load_cnt      (ctr_load_cnt),
    .active        (ctr_active),
    .stall         (ctr_stall),
    .scl_drive_low (scl_drive_low),
    .sda_drive_low (sda_drive_low)
  );

  assign phase_end = ctr_last;

  // R11
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ready |-> $stable(tmg));

  // R12
  phase_end_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_end |-> !cmd_ready);

endmodule

// File: tb/scl_phase_gen_test.sv
module scl_phase_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_mode = 2'b10;
  logic [7:0] cfg_low_cnt = 8'd100;
  logic [7:0] cfg_high_cnt = 8'd70;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic       cmd_bit = 1'b1;
  logic       cmd_ready, cmd_done, phase_end;
  logic       scl_line, scl_drive_low, sda_drive_low;
  int         stretch_left = 0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  int seg_code [0:15];
  int seg_len  [0:15];
  int nseg;
  int exp_code [0:15];
  int exp_len  [0:15];
  int nexp;
  int npe;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign scl_line = !scl_drive_low && (stretch_left == 0);

  always @(posedge clk)
    if (!scl_drive_low && stretch_left > 0) stretch_left <= stretch_left - 1;

  scl_phase_gen uut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_low_cnt(cfg_low_cnt),
    .cfg_high_cnt(cfg_high_cnt), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bit(cmd_bit), .cmd_ready(cmd_ready), .cmd_done(cmd_done),
    .phase_end(phase_end), .scl_line(scl_line), .scl_drive_low(scl_drive_low),
    .sda_drive_low(sda_drive_low)
  );

  // independent model of the timing rules
  function automatic int scale_for(input logic [1:0] m);
    if (m == 2'b01) return 4;
    if (m == 2'b10) return 1;
    return 8;
  endfunction

  function automatic int floor_for(input logic [1:0] m, input bit high);
    if (m == 2'b01) return high ? 39 : 59;
    if (m == 2'b10) return high ? 63 : 94;
    return high ? 79 : 118;
  endfunction

  function automatic int cycles_for(input logic [1:0] m, input int v, input bit high);
    int f = floor_for(m, high);
    return ((v < f) ? f : v) * scale_for(m);
  endfunction

  task automatic check_int(input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic exp_clear();
    nexp = 0;
  endtask

  task automatic exp_add(input int code, input int len);
    if (len > 0) begin
      exp_code[nexp] = code;
      exp_len[nexp]  = len;
      nexp++;
    end
  endtask

  task automatic check_segs(input string what);
    int bad = -1;
    checks++;
    if (nseg != nexp) bad = 99;
    else
      for (int i = 0; i < nseg; i++)
        if (bad < 0 && (seg_code[i] != exp_code[i] || seg_len[i] != exp_len[i])) bad = i;
    if (bad == 99) begin
      errors++;
      $display("FAIL %s: got %0d segments expected %0d", what, nseg, nexp);
    end else if (bad >= 0) begin
      errors++;
      $display("FAIL %s: segment %0d got code %0d len %0d expected code %0d len %0d",
               what, bad, seg_code[bad], seg_len[bad], exp_code[bad], exp_len[bad]);
    end
  endtask

  // code = {scl pulled low, sda pulled low, scl held low by slave}
  // poke: 0 none, 1 stray STOP request at cycle 5, 2 settings change at cycle 10
  task automatic run_cmd(input logic [1:0] op, input logic b, input int stretch, input int poke);
    int guard = 0;
    @(negedge clk);
    cmd_op = op; cmd_bit = b; cmd_valid = 1'b1; stretch_left = stretch;
    @(negedge clk);
    cmd_valid = 1'b0;
    nseg = 0; npe = 0;
    while (!cmd_done && guard < 20000) begin
      int code = {29'd0, scl_drive_low, sda_drive_low, (!scl_drive_low && !scl_line)};
      if (nseg == 0 || seg_code[nseg-1] != code) begin
        if (nseg < 16) begin
          seg_code[nseg] = code; seg_len[nseg] = 1; nseg++;
        end
      end else begin
        seg_len[nseg-1]++;
      end
      if (phase_end) npe++;
      if (poke == 1 && guard == 5) begin cmd_valid = 1'b1; cmd_op = 2'b10; end
      else cmd_valid = 1'b0;
      if (poke == 2 && guard == 10) begin
        cfg_mode = 2'b00; cfg_low_cnt = 8'd100; cfg_high_cnt = 8'd70;
      end
      guard++;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    if (guard >= 20000) check_int("command never completed", 0, 1);
  endtask

  task automatic set_cfg(input logic [1:0] m, input int lo, input int hi);
    @(negedge clk);
    cfg_mode = m; cfg_low_cnt = 8'(lo); cfg_high_cnt = 8'(hi);
  endtask

  task automatic test_reset();
    check_int("R1 scl_drive_low after reset", int'(scl_drive_low), 0);
    check_int("R1 sda_drive_low after reset", int'(sda_drive_low), 0);
    check_int("R1 cmd_ready after reset", int'(cmd_ready), 1);
    check_int("R1 cmd_done after reset", int'(cmd_done), 0);
  endtask

  // free bus sequence in Fm+ 100/70: start, bits, repeated start, wait, stop
  task automatic test_basic_sequence();
    set_cfg(2'b10, 100, 70);
    run_cmd(2'b01, 1'b1, 0, 0);
    exp_clear(); exp_add(2, 70);
    check_segs("R6 start on free bus");
    check_int("R12 phase ends of start", npe, 1);

    run_cmd(2'b00, 1'b0, 0, 0);
    exp_clear(); exp_add(6, 100); exp_add(2, 70);
    check_segs("R3 bit 0 timing");
    check_int("R12 phase ends of bit", npe, 2);

    run_cmd(2'b00, 1'b1, 13, 0);
    exp_clear(); exp_add(4, 100); exp_add(1, 13); exp_add(0, 70);
    check_segs("R5 bit 1 with clock stretch");

    run_cmd(2'b01, 1'b1, 0, 0);
    exp_clear(); exp_add(4, 100); exp_add(0, 70); exp_add(2, 70);
    check_segs("R7 repeated start");
    check_int("R12 phase ends of repeated start", npe, 3);

    run_cmd(2'b11, 1'b1, 0, 0);
    exp_clear(); exp_add(6, 100);
    check_segs("R9 wait on owned bus");
    check_int("R12 phase ends of wait", npe, 1);

    run_cmd(2'b10, 1'b1, 5, 0);
    exp_clear(); exp_add(6, 100); exp_add(3, 5); exp_add(2, 70); exp_add(0, 100);
    check_segs("R8 stop with stretched setup");
    check_int("R12 phase ends of stop", npe, 3);
    check_int("R8 scl released after stop", int'(scl_drive_low), 0);
    check_int("R8 sda released after stop", int'(sda_drive_low), 0);

    run_cmd(2'b10, 1'b1, 0, 0);
    check_int("R8 stop on free bus has no timed cycles", nseg, 0);
    check_int("R12 no phase end for stop on free bus", npe, 0);

    run_cmd(2'b11, 1'b1, 0, 0);
    exp_clear(); exp_add(0, 100);
    check_segs("R9 wait on free bus");
  endtask

  task automatic test_mode(input logic [1:0] m, input int lo, input int hi, input logic b,
                           input string tag);
    int lc = cycles_for(m, lo, 1'b0);
    int hc = cycles_for(m, hi, 1'b1);
    set_cfg(m, lo, hi);
    run_cmd(2'b01, 1'b1, 0, 0);
    exp_clear(); exp_add(2, hc);
    check_segs({tag, " start"});
    run_cmd(2'b00, b, 0, 0);
    exp_clear(); exp_add(b ? 4 : 6, lc); exp_add(b ? 0 : 2, hc);
    check_segs({tag, " bit"});
    run_cmd(2'b10, 1'b1, 0, 0);
    exp_clear(); exp_add(6, lc); exp_add(2, hc); exp_add(0, lc);
    check_segs({tag, " stop"});
  endtask

  task automatic test_frozen_cfg();
    set_cfg(2'b10, 100, 70);
    run_cmd(2'b01, 1'b1, 0, 0);
    run_cmd(2'b00, 1'b0, 0, 2);
    exp_clear(); exp_add(6, 100); exp_add(2, 70);
    check_segs("R11 settings change during bit ignored");
    run_cmd(2'b00, 1'b1, 0, 0);
    exp_clear(); exp_add(4, cycles_for(2'b00, 100, 1'b0)); exp_add(0, cycles_for(2'b00, 70, 1'b1));
    check_segs("R11 new settings apply to next bit");
  endtask

  task automatic test_busy_request();
    set_cfg(2'b10, 100, 70);
    run_cmd(2'b00, 1'b1, 0, 1);
    exp_clear(); exp_add(4, 100); exp_add(0, 70);
    check_segs("R10 bit unaffected by stray request");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check_int("R10 stray stop ignored, scl still owned", int'(scl_drive_low), 1);
      check_int("R10 done is a single pulse", int'(cmd_done), 0);
    end
    run_cmd(2'b10, 1'b1, 0, 0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_basic_sequence();
    test_mode(2'b10, 10, 5, 1'b0, "R4 Fm+ counts raised to floor");
    test_mode(2'b01, 60, 40, 1'b1, "R2 fast mode scale 4");
    test_mode(2'b01, 0, 0, 1'b0, "R4 fast mode floors");
    test_mode(2'b00, 0, 0, 1'b1, "R2 standard mode scale 8 floors");
    test_mode(2'b11, 120, 80, 1'b0, "R2 reserved code as standard");
    test_frozen_cfg();
    test_busy_request();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule